// File: doc/BRIEF.md
# Single-Step Shifter with Barrel Left Rotator

This block moves an N-bit word in two independent ways. The single-step path moves the word by one position under a three-bit control word. Depending on that word it passes the input through, shifts it left or right, or rotates it left or right. For logical shifts the entering bit comes from one of two serial fill inputs, one for each side. An arithmetic mode replaces the fill bits with the values that two's-complement arithmetic needs. Every output bit comes from its own four-input multiplexer.

The second path is a log-depth barrel rotator. It rotates the same input word left by any amount from 0 to N-1. It has one rank of two-input multiplexers per bit of the amount.

Both results are registered on the rising clock edge and appear one cycle after their inputs. A synchronous active-high reset clears them.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst` is 1 at a rising edge, both `step_out` and `rot_out` become 0 after that edge.
- R2: Control bit 2 (`ctl[2]`) equal to 0 makes `step_out` equal to `din` one cycle later, whatever `ctl[1:0]`, `arith`, `fill_left` and `fill_right` are.
- R3: With `ctl` = 3'b100 (bit 2 = move, bit 1 = 0 for left, bit 0 = 0 for shift) and `arith` = 0, `step_out` is `{din[W-2:0], fill_right}` one cycle later.
- R4: With `ctl` = 3'b110 (bit 1 = 1 for right) and `arith` = 0, `step_out` is `{fill_left, din[W-1:1]}` one cycle later.
- R5: With `ctl` = 3'b101 (bit 0 = 1 for rotate), `step_out` is `{din[W-2:0], din[W-1]}`. With `ctl` = 3'b111 it is `{din[0], din[W-1:1]}`. In both cases `arith` and the fill inputs have no effect.
- R6: With `ctl` = 3'b100 and `arith` = 1, a zero enters from the right and `fill_right` is ignored. The result equals `din` times 2 modulo 2^W.
- R7: With `ctl` = 3'b110 and `arith` = 1, the MSB of `din` is copied into the MSB position and `fill_left` is ignored. The result equals the signed value of `din` divided by 2 and rounded toward minus infinity.
- R8: `rot_out` equals `din` rotated left by `rot_amt` positions (0 to W-1) one cycle later, independent of `ctl`, `arith` and the fill inputs.
- R9: The barrel result keeps the number of ones in `din`, and for `rot_amt` = 0 it equals `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | W | Data word |
| ctl | input | 3 | Bit 2 move enable, bit 1 direction (1 = right), bit 0 rotate |
| fill_left | input | 1 | Bit entering at the MSB on a logical right shift |
| fill_right | input | 1 | Bit entering at the LSB on a logical left shift |
| arith | input | 1 | Arithmetic mode for shifts |
| rot_amt | input | AW | Left rotate amount for the barrel path |
| step_out | output | W | Registered single-step result |
| rot_out | output | W | Registered barrel rotate result |

## Verification
The hardest cases are the ones where an input must be shown to have no effect. A fill input should be ignored during a rotate or an arithmetic shift. The direction, rotate, mode and fill inputs should all be ignored when the move bit is clear. A simple sweep would not catch a defect there, because the ignored input usually equals the bit that is expected anyway. The stimulus therefore sweeps every 8-bit word against every control code, both modes and all four fill combinations. Each ignored input is then driven both to the value that would corrupt the result and to the opposite value. The rotate amount is derived from the data and the loop index, so every amount meets many different words.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  // Control word layout: bit 2 move, bit 1 right, bit 0 rotate
  typedef struct packed {
    logic move;
    logic right;
    logic rot;
  } shrot_ctl_t;

  // Per-bit multiplexer source
  typedef enum logic [1:0] {
    SRC_SAME  = 2'd0,
    SRC_LOWER = 2'd1,
    SRC_UPPER = 2'd2,
    SRC_EDGE  = 2'd3
  } shrot_src_e;

endpackage

// File: rtl/shrot_step.sv
module shrot_step
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  shrot_ctl_t   ctl,
  input  logic         fill_left,
  input  logic         fill_right,
  input  logic         arith,
  output logic [W-1:0] dout
);

  logic edge_lo;  // enters bit 0 on a left move
  logic edge_hi;  // enters bit W-1 on a right move

  always_comb begin
    if (ctl.rot) begin
      edge_lo = din[W-1];
      edge_hi = din[0];
    end else if (arith) begin
      edge_lo = 1'b0;
      edge_hi = din[W-1];
    end else begin
      edge_lo = fill_right;
      edge_hi = fill_left;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic       lower_nb;
    logic       upper_nb;
    logic       edge_in;
    shrot_src_e src;

    if (i == 0) begin : g_lo_end
      assign lower_nb = edge_lo;
    end else begin : g_lo_mid
      assign lower_nb = din[i-1];
    end

    if (i == W-1) begin : g_hi_end
      assign upper_nb = edge_hi;
    end else begin : g_hi_mid
      assign upper_nb = din[i+1];
    end

    assign edge_in = ctl.right ? edge_hi : edge_lo;

    always_comb begin
      if (!ctl.move)
        src = SRC_SAME;
      else if (ctl.right)
        src = (i == W-1) ? SRC_EDGE : SRC_UPPER;
      else
        src = (i == 0) ? SRC_EDGE : SRC_LOWER;
    end

    always_comb begin
      unique case (src)
        SRC_SAME:  dout[i] = din[i];
        SRC_LOWER: dout[i] = lower_nb;
        SRC_UPPER: dout[i] = upper_nb;
        SRC_EDGE:  dout[i] = edge_in;
        default:   dout[i] = din[i];
      endcase
    end
  end

endmodule

// File: rtl/shrot_barrel.sv
module shrot_barrel #(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] rank [0:AW];

  assign rank[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_rank
    localparam int STEP = (1 << k) % W;
    for (genvar i = 0; i < W; i++) begin : g_mux
      localparam int SRC = (i + W - STEP) % W;
      assign rank[k+1][i] = amt[k] ? rank[k][SRC] : rank[k][i];
    end
  end

  assign dout = rank[AW];

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shrot_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [2:0]    ctl,
  input  logic          fill_left,
  input  logic          fill_right,
  input  logic          arith,
  input  logic [AW-1:0] rot_amt,
  output logic [W-1:0]  step_out,
  output logic [W-1:0]  rot_out
);

  logic [W-1:0] step_nxt;
  logic [W-1:0] rot_nxt;

  shrot_step #(.W(W)) step_i (
    .din        (din),
    .ctl        (shrot_ctl_t'(ctl)),
    .fill_left  (fill_left),
    .fill_right (fill_right),
    .arith      (arith),
    .dout       (step_nxt)
  );

  shrot_barrel #(.W(W), .AW(AW)) barrel_i (
    .din  (din),
    .amt  (rot_amt),
    .dout (rot_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_out <= '0;
      rot_out  <= '0;
    end else begin
      step_out <= step_nxt;
      rot_out  <= rot_nxt;
    end
  end

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk #(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  din,
  input logic [2:0]    ctl,
  input logic          fill_left,
  input logic          fill_right,
  input logic          arith,
  input logic [AW-1:0] rot_amt,
  input logic [W-1:0]  step_out,
  input logic [W-1:0]  rot_out
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (step_out == '0 && rot_out == '0));

  a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
    !ctl[2] |=> step_out == $past(din));

  a_r3_left_fill: assert property (@(posedge clk) disable iff (rst)
    (ctl == 3'b100 && !arith) |=>
      (step_out[0] == $past(fill_right) && step_out[W-1:1] == $past(din[W-2:0])));

  a_r4_right_fill: assert property (@(posedge clk) disable iff (rst)
    (ctl == 3'b110 && !arith) |=>
      (step_out[W-1] == $past(fill_left) && step_out[W-2:0] == $past(din[W-1:1])));

  a_r5_rotate_left: assert property (@(posedge clk) disable iff (rst)
    ctl == 3'b101 |=> (step_out[0] == $past(din[W-1]) && step_out[W-1:1] == $past(din[W-2:0])));

  a_r5_rotate_right: assert property (@(posedge clk) disable iff (rst)
    ctl == 3'b111 |=> (step_out[W-1] == $past(din[0]) && step_out[W-2:0] == $past(din[W-1:1])));

  a_r6_arith_left: assert property (@(posedge clk) disable iff (rst)
    (ctl == 3'b100 && arith) |=> (step_out[0] == 1'b0));

  a_r7_arith_right: assert property (@(posedge clk) disable iff (rst)
    (ctl == 3'b110 && arith) |=>
      (step_out[W-1] == $past(din[W-1]) && step_out[W-2] == $past(din[W-1])));

  a_r9_ones_kept: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(rot_out) == $countones($past(din)));

  a_r9_zero_amount: assert property (@(posedge clk) disable iff (rst)
    rot_amt == '0 |=> rot_out == $past(din));

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.W(W), .AW(AW)) chk_i (.*);

// File: tb/shift_rotate_unit_tb_top.sv
`timescale 1ns/1ps
module shift_rotate_unit_tb_top;

  localparam int W    = 8;
  localparam int AW   = 3;
  localparam int SPAN = 1 << W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  din = '0;
  logic [2:0]    ctl = '0;
  logic          fill_left = 1'b0;
  logic          fill_right = 1'b0;
  logic          arith = 1'b0;
  logic [AW-1:0] rot_amt = '0;
  logic [W-1:0]  step_out;
  logic [W-1:0]  rot_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shift_rotate_unit #(.W(W), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .din(din), .ctl(ctl),
    .fill_left(fill_left), .fill_right(fill_right), .arith(arith),
    .rot_amt(rot_amt), .step_out(step_out), .rot_out(rot_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int step_model(int d, int c, int a, int fl, int fr, output string tag);
    int msb = d / (SPAN / 2);
    if (c < 4) begin tag = "R2"; return d; end
    case (c)
      4: if (a == 1) begin tag = "R6"; return (d * 2) % SPAN; end
         else begin tag = "R3"; return (d * 2) % SPAN + fr; end
      6: if (a == 1) begin tag = "R7"; return d / 2 + msb * (SPAN / 2); end
         else begin tag = "R4"; return d / 2 + fl * (SPAN / 2); end
      5: begin tag = "R5"; return (d * 2) % SPAN + msb; end
      default: begin tag = "R5"; return d / 2 + (d % 2) * (SPAN / 2); end
    endcase
  endfunction

  function automatic int rot_model(int d, int k);
    return ((d * (1 << k)) % SPAN) + d / (1 << (W - k));
  endfunction

  initial begin
    string tag;
    int    exp_step;
    // R1: reset with nonzero inputs
    din = 8'hA5; ctl = 3'b101; rot_amt = 3'd3; fill_left = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 step", int'(step_out), 0);
    check("R1 rot", int'(rot_out), 0);
    rst = 1'b0;
    for (int d = 0; d < SPAN; d++) begin
      for (int c = 0; c < 8; c++) begin
        for (int a = 0; a < 2; a++) begin
          for (int f = 0; f < 4; f++) begin
            int k = (d + c * 3 + a * 5 + f) % W;
            @(negedge clk);
            din = W'(d); ctl = 3'(c); arith = a[0];
            fill_left = f[1]; fill_right = f[0]; rot_amt = AW'(k);
            @(negedge clk);
            exp_step = step_model(d, c, a, f / 2, f % 2, tag);
            check(tag, int'(step_out), exp_step);
            if (k == 0) check("R9", int'(rot_out), d);
            else        check("R8", int'(rot_out), rot_model(d, k));
          end
        end
      end
    end
    // R1: reset again mid-run
    @(negedge clk); rst = 1'b1; din = 8'hFF; ctl = 3'b100;
    @(negedge clk);
    check("R1 step", int'(step_out), 0);
    check("R1 rot", int'(rot_out), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule